// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block steers one coprocessor instruction from start to finish. Five instruction classes are supported: an internal data operation, a register move into the coprocessor, a register move out of it, a multi-word load and a multi-word store. Each one is presented to an external coprocessor, which answers every handshake cycle with a two-bit response. For the memory classes the block also produces the word address for each beat of the burst.

First the block checks a per-coprocessor permission mask. It then presents the instruction. While the coprocessor stays busy, the block polls it again after a gap cycle, and pending interrupts may cut the wait short. At the end the block reports one of four outcomes with a single-cycle completion pulse: complete, undefined instruction, abort or interrupted. The coprocessor and the memory are outside the block. The block only drives the phase code, the address and the read/write strobes.

Top module: `cop_seq`

## Requirements
- R1: If the permission bit `perm_mask_i[cpnum_i]` is 0, the instruction ends with outcome undefined (1). The coprocessor never sees a non-idle phase. `done_o` rises on the second falling edge after the start edge (two cycles).
- R2: The first handshake uses phase code 1. Each busy answer (response 1) inserts one cycle of idle phase (0), followed by a re-poll with phase code 2. A data operation with k busy answers completes 3+2k cycles after start and presents k+1 polls.
- R3: In each gap cycle, pending requests are arbitrated in this order: reset request first, then the fast interrupt if `fmask_i` is 0, then the normal interrupt if `imask_i` is 0. A taken request ends the instruction with outcome interrupted (3). The kind is reported on `int_kind_o` as 1 = reset, 2 = fast, 3 = normal, and phase code 3 (abandon) is shown in the completion cycle.
- R4: Interrupt lines have no effect when the coprocessor never answers busy. The instruction completes with outcome 0.
- R5: A cannot answer (response 2) ends a load or store with outcome abort (2). For a data operation or a register move in either direction, it ends with outcome undefined (1).
- R6: A register move out of the coprocessor returns `cp_rdata_i` on `result_o` when answered done (0). When answered cannot, it returns the four flag bits `flags_i` in `result_o[31:28]` with all other bits zero.
- R7: Bursts are post-indexed. The first data beat (phase 5, after one transfer cycle with phase 4) uses `addr_i`. Every increment answer (3) adds another beat at the previous address plus 4, and a done answer ends the burst. A load asserts `mem_rd_o` and a store asserts `mem_wr_o` on each beat.
- R8: An address exception is any address with a bit set at position 26 or above. It makes a load or store end with outcome abort. A store additionally aborts for an address below 32 (the vector area). A load there completes normally.
- R9: If `ext_abort_i` is high in any transfer or data cycle, the burst still runs to its end and then reports outcome abort.
- R10: `done_o` is high for exactly one cycle per instruction. While an instruction is in progress, `start_i` is ignored.
- R11: After reset, `done_o`, `mem_rd_o` and `mem_wr_o` are 0 and the phase is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction (accepted when idle) |
| cls_i | input | 3 | Class: 0 data op, 1 move to coprocessor, 2 move from coprocessor, 3 load, 4 store |
| cpnum_i | input | 4 | Coprocessor number |
| addr_i | input | 32 | Burst start address |
| perm_mask_i | input | 16 | Access permission, one bit per coprocessor |
| rst_req_i | input | 1 | Pending reset request |
| fiq_i | input | 1 | Fast interrupt request |
| irq_i | input | 1 | Normal interrupt request |
| fmask_i | input | 1 | Fast interrupt mask (1 = masked) |
| imask_i | input | 1 | Normal interrupt mask (1 = masked) |
| flags_i | input | 4 | Condition flags returned on a refused register read |
| cp_resp_i | input | 2 | Coprocessor answer: 0 done, 1 busy, 2 cannot, 3 increment |
| cp_rdata_i | input | 32 | Coprocessor register value |
| ext_abort_i | input | 1 | External memory abort |
| cp_phase_o | output | 3 | Phase to coprocessor: 0 idle, 1 first, 2 poll, 3 abandon, 4 transfer, 5 data |
| mem_addr_o | output | 32 | Current burst word address |
| mem_rd_o | output | 1 | Load beat strobe |
| mem_wr_o | output | 1 | Store beat strobe |
| done_o | output | 1 | Single-cycle completion pulse |
| outcome_o | output | 2 | 0 complete, 1 undefined, 2 abort, 3 interrupted (valid with done_o) |
| int_kind_o | output | 2 | 0 none, 1 reset, 2 fast, 3 normal (valid with done_o) |
| result_o | output | 32 | Register read result |

## Verification
The bench targets the busy-wait loop by counting gap cycles and polls. A design that skipped the idle gap, or sent the first phase code again, would fail the cycle count. The bench also plays every combination of simultaneous reset request, fast and normal interrupt and mask. A wrong priority order would report the wrong kind, and a wrongly polarised mask would abandon instructions that should finish. Burst tests cover zero and several increments, the store-only vector area and late external aborts. An off-by-one address step or a dropped abort would appear in the logged beat addresses or in the final outcome. A restart pulse during a busy instruction catches a sequencer that re-enters on `start_i` and emits a second completion pulse.

// File: rtl/cop_seq_pkg.sv
package cop_seq_pkg;
  typedef enum logic [2:0] {
    OP_DATA  = 3'd0,
    OP_PUT   = 3'd1,
    OP_GET   = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STORE = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    RS_DONE = 2'd0,
    RS_BUSY = 2'd1,
    RS_CANT = 2'd2,
    RS_INC  = 2'd3
  } resp_e;

  typedef enum logic [1:0] {
    OC_OK    = 2'd0,
    OC_UNDEF = 2'd1,
    OC_ABORT = 2'd2,
    OC_INT   = 2'd3
  } outcome_e;

  typedef enum logic [1:0] {
    IK_NONE  = 2'd0,
    IK_RESET = 2'd1,
    IK_FAST  = 2'd2,
    IK_NORM  = 2'd3
  } ikind_e;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_FIRST   = 3'd1,
    PH_POLL    = 3'd2,
    PH_ABANDON = 3'd3,
    PH_XFER    = 3'd4,
    PH_DATA    = 3'd5
  } phase_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_FIRST, S_WAIT, S_POLL, S_XFER, S_DATA, S_DONE, S_EXC
  } state_e;
endpackage

// File: rtl/cop_seq_arb.sv
module cop_seq_arb
  import cop_seq_pkg::*;
(
  input  logic   rst_req_i,
  input  logic   fiq_i,
  input  logic   irq_i,
  input  logic   fmask_i,
  input  logic   imask_i,
  output logic   take_o,
  output ikind_e kind_o
);
  logic fiq_live, irq_live;

  assign fiq_live = fiq_i && !fmask_i;
  assign irq_live = irq_i && !imask_i;

  always_comb begin
    if (rst_req_i)     kind_o = IK_RESET;
    else if (fiq_live) kind_o = IK_FAST;
    else if (irq_live) kind_o = IK_NORM;
    else               kind_o = IK_NONE;
  end

  assign take_o = rst_req_i || fiq_live || irq_live;

  // R3
  always_comb begin
    masked_quiet_chk: assert (!(!rst_req_i && (fmask_i || !fiq_i) && (imask_i || !irq_i)) || !take_o);
  end
endmodule

// File: rtl/cop_seq_agen.sv
module cop_seq_agen #(
  parameter int ADDR_W     = 32,
  parameter int LEGAL_W    = 26,
  parameter int VEC_BYTES  = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              adv_i,
  input  logic              is_store_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              exc_o
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] VEC_TOP = ADDR_W'(VEC_BYTES);

  logic [ADDR_W-1:0] addr_q;
  logic              out_of_range, in_vectors;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (load_i) addr_q <= base_i;
    else if (adv_i)  addr_q <= addr_q + STEP;
  end

  assign out_of_range = |addr_q[ADDR_W-1:LEGAL_W];
  assign in_vectors   = addr_q < VEC_TOP;
  assign exc_o        = out_of_range || (is_store_i && in_vectors);
  assign addr_o       = addr_q;

  // R7
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i) |=> (addr_o == $past(addr_o) + STEP));
endmodule

// File: rtl/cop_seq_fsm.sv
module cop_seq_fsm
  import cop_seq_pkg::*;
#(
  parameter int NUM_CP = 16,
  parameter int DATA_W = 32,
  parameter int FLAG_W = 4,
  localparam int CP_W  = $clog2(NUM_CP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  op_e               cls_i,
  input  logic [CP_W-1:0]   cp_i,
  input  logic [NUM_CP-1:0] perm_i,
  input  resp_e             resp_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              ext_abort_i,
  input  logic              addr_exc_i,
  input  logic              take_i,
  input  ikind_e            kind_i,
  output logic              load_o,
  output logic              adv_o,
  output logic              is_store_o,
  output phase_e            phase_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              done_o,
  output outcome_e          outcome_o,
  output ikind_e            kind_o,
  output logic [DATA_W-1:0] result_o
);
  state_e            state_q, state_d;
  op_e               cls_q;
  logic [CP_W-1:0]   cp_q;
  outcome_e          oc_q, oc_d;
  ikind_e            kind_q, kind_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              abort_q, abort_d;
  logic              is_mem;

  assign is_mem = (cls_q == OP_LOAD) || (cls_q == OP_STORE);
  assign load_o = (state_q == S_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    oc_d    = oc_q;
    kind_d  = kind_q;
    res_d   = res_q;
    abort_d = abort_q;
    adv_o   = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d = S_CHECK;
        oc_d    = OC_OK;
        kind_d  = IK_NONE;
        res_d   = '0;
        abort_d = 1'b0;
      end
      S_CHECK: begin
        if (!perm_i[cp_q]) begin
          state_d = S_EXC;
          oc_d    = OC_UNDEF;
        end else begin
          state_d = S_FIRST;
          abort_d = is_mem && addr_exc_i;
        end
      end
      S_FIRST, S_POLL: begin
        unique case (resp_i)
          RS_BUSY: state_d = S_WAIT;
          RS_CANT: begin
            state_d = S_EXC;
            oc_d    = is_mem ? OC_ABORT : OC_UNDEF;
            if (cls_q == OP_GET) res_d = {flags_i, {(DATA_W-FLAG_W){1'b0}}};
          end
          default: begin
            state_d = is_mem ? S_XFER : S_DONE;
            if (cls_q == OP_GET) res_d = rdata_i;
          end
        endcase
      end
      S_WAIT: begin
        if (take_i) begin
          state_d = S_EXC;
          oc_d    = OC_INT;
          kind_d  = kind_i;
        end else begin
          state_d = S_POLL;
        end
      end
      S_XFER: begin
        state_d = S_DATA;
        abort_d = abort_q || ext_abort_i;
      end
      S_DATA: begin
        abort_d = abort_q || ext_abort_i;
        if (resp_i == RS_INC) begin
          adv_o = 1'b1;
        end else begin
          state_d = S_DONE;
          oc_d    = (abort_q || ext_abort_i) ? OC_ABORT : OC_OK;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cls_q   <= OP_DATA;
      cp_q    <= '0;
      oc_q    <= OC_OK;
      kind_q  <= IK_NONE;
      res_q   <= '0;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      oc_q    <= oc_d;
      kind_q  <= kind_d;
      res_q   <= res_d;
      abort_q <= abort_d;
      if (load_o) begin
        cls_q <= cls_i;
        cp_q  <= cp_i;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      S_FIRST: phase_o = PH_FIRST;
      S_POLL:  phase_o = PH_POLL;
      S_XFER:  phase_o = PH_XFER;
      S_DATA:  phase_o = PH_DATA;
      S_EXC:   phase_o = (oc_q == OC_INT) ? PH_ABANDON : PH_IDLE;
      default: phase_o = PH_IDLE;
    endcase
  end

  assign is_store_o = (cls_q == OP_STORE);
  assign mem_rd_o   = (state_q == S_DATA) && (cls_q == OP_LOAD);
  assign mem_wr_o   = (state_q == S_DATA) && (cls_q == OP_STORE);
  assign done_o     = (state_q == S_DONE) || (state_q == S_EXC);
  assign outcome_o  = oc_q;
  assign kind_o     = kind_q;
  assign result_o   = res_q;

  // R1
  perm_undef_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CHECK && !perm_i[cp_q]) |=> (done_o && outcome_o == OC_UNDEF));
  // R3
  int_abandon_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT && take_i) |=> (done_o && outcome_o == OC_INT && phase_o == PH_ABANDON));
  // R9
  late_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DATA && resp_i != RS_INC && ext_abort_i) |=> (done_o && outcome_o == OC_ABORT));
endmodule

// File: rtl/cop_seq.sv
module cop_seq
  import cop_seq_pkg::*;
#(
  parameter int NUM_CP     = 16,
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FLAG_W     = 4,
  parameter int LEGAL_W    = 26,
  parameter int VEC_BYTES  = 32,
  parameter int WORD_BYTES = 4,
  localparam int CP_W      = $clog2(NUM_CP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        cls_i,
  input  logic [CP_W-1:0]   cpnum_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_CP-1:0] perm_mask_i,
  input  logic              rst_req_i,
  input  logic              fiq_i,
  input  logic              irq_i,
  input  logic              fmask_i,
  input  logic              imask_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [1:0]        cp_resp_i,
  input  logic [DATA_W-1:0] cp_rdata_i,
  input  logic              ext_abort_i,
  output logic [2:0]        cp_phase_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              done_o,
  output logic [1:0]        outcome_o,
  output logic [1:0]        int_kind_o,
  output logic [DATA_W-1:0] result_o
);
  logic     load, adv, is_store, addr_exc, take;
  ikind_e   arb_kind, kind;
  phase_e   phase;
  outcome_e oc;

  cop_seq_arb i_arb (
    .rst_req_i (rst_req_i),
    .fiq_i     (fiq_i),
    .irq_i     (irq_i),
    .fmask_i   (fmask_i),
    .imask_i   (imask_i),
    .take_o    (take),
    .kind_o    (arb_kind)
  );

  cop_seq_agen #(
    .ADDR_W     (ADDR_W),
    .LEGAL_W    (LEGAL_W),
    .VEC_BYTES  (VEC_BYTES),
    .WORD_BYTES (WORD_BYTES)
  ) i_agen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .base_i     (addr_i),
    .adv_i      (adv),
    .is_store_i (is_store),
    .addr_o     (mem_addr_o),
    .exc_o      (addr_exc)
  );

  cop_seq_fsm #(
    .NUM_CP (NUM_CP),
    .DATA_W (DATA_W),
    .FLAG_W (FLAG_W)
  ) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cls_i       (op_e'(cls_i)),
    .cp_i        (cpnum_i),
    .perm_i      (perm_mask_i),
    .resp_i      (resp_e'(cp_resp_i)),
    .flags_i     (flags_i),
    .rdata_i     (cp_rdata_i),
    .ext_abort_i (ext_abort_i),
    .addr_exc_i  (addr_exc),
    .take_i      (take),
    .kind_i      (arb_kind),
    .load_o      (load),
    .adv_o       (adv),
    .is_store_o  (is_store),
    .phase_o     (phase),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .done_o      (done_o),
    .outcome_o   (oc),
    .kind_o      (kind),
    .result_o    (result_o)
  );

  assign cp_phase_o = phase;
  assign outcome_o  = oc;
  assign int_kind_o = kind;

  // R2
  gap_before_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cp_phase_o == PH_POLL) |-> ($past(cp_phase_o) == PH_IDLE));
  // R10
  single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  // R3
  reset_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && outcome_o == OC_INT && $past(rst_req_i)) |-> (int_kind_o == IK_RESET));
endmodule

// File: tb/test_cop_seq.sv
module test_cop_seq;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [2:0]  cls_i = '0;
  logic [3:0]  cpnum_i = '0;
  logic [31:0] addr_i = '0;
  logic [15:0] perm_mask_i = 16'hFFDF;
  logic        rst_req_i = 0, fiq_i = 0, irq_i = 0, fmask_i = 0, imask_i = 0;
  logic [3:0]  flags_i = 4'b1010;
  logic [1:0]  cp_resp_i = '0;
  logic [31:0] cp_rdata_i = 32'hCAFE_0123;
  logic        ext_abort_i = 0;
  logic [2:0]  cp_phase_o;
  logic [31:0] mem_addr_o, result_o;
  logic        mem_rd_o, mem_wr_o, done_o;
  logic [1:0]  outcome_o, int_kind_o;

  int checks = 0, errors = 0;
  int busy_n, inc_n, abort_at, poll_cnt, data_cnt, rd_cnt, wr_cnt;
  logic [1:0]  final_resp;
  logic [31:0] addr_log [16];
  logic        saw_abandon, saw_active;
  logic [1:0]  oc, kd;
  logic [31:0] res;
  int          cyc, dones, poke_at;

  always #2.5 clk_i = ~clk_i;

  cop_seq i_cop_seq (.*);

  // coprocessor and memory model, driven away from the active edge
  always @(negedge clk_i) begin
    ext_abort_i = 1'b0;
    case (cp_phase_o)
      3'd1, 3'd2: begin
        cp_resp_i = (poll_cnt < busy_n) ? 2'd1 : final_resp;
        poll_cnt++;
      end
      3'd5: begin
        cp_resp_i = (data_cnt < inc_n) ? 2'd3 : 2'd0;
        if (data_cnt < 16) addr_log[data_cnt] = mem_addr_o;
        rd_cnt += int'(mem_rd_o);
        wr_cnt += int'(mem_wr_o);
        ext_abort_i = (data_cnt == abort_at);
        data_cnt++;
      end
      default: cp_resp_i = 2'd0;
    endcase
    if (cp_phase_o == 3'd3) saw_abandon = 1'b1;
    if (cp_phase_o != 3'd0) saw_active = 1'b1;
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] cls, input logic [3:0] cp, input logic [31:0] addr,
                        input int bn, input logic [1:0] fr, input int incn, input int abat);
    busy_n = bn; final_resp = fr; inc_n = incn; abort_at = abat;
    poll_cnt = 0; data_cnt = 0; rd_cnt = 0; wr_cnt = 0;
    saw_abandon = 0; saw_active = 0;
    @(negedge clk_i);
    cls_i = cls; cpnum_i = cp; addr_i = addr; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; cyc = 1; dones = 0;
    while (!done_o && cyc < 200) begin
      start_i = (cyc == poke_at);
      if (start_i) begin cls_i = 3'd0; cpnum_i = 4'd5; end
      @(negedge clk_i);
      cyc++;
    end
    start_i = 1'b0;
    oc = outcome_o; kd = int_kind_o; res = result_o;
    dones = int'(done_o);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      dones += int'(done_o);
    end
  endtask

  task automatic t_reset;
    chk(!done_o && cp_phase_o == 0 && !mem_rd_o && !mem_wr_o, "R11 reset state", {done_o, cp_phase_o}, 0);
  endtask

  task automatic t_perm;
    run_op(3'd0, 4'd5, 32'h100, 0, 2'd0, 0, -1);
    chk(oc == 2'd1, "R1 outcome", oc, 1);
    chk(cyc == 2, "R1 latency", cyc, 2);
    chk(!saw_active, "R1 no handshake", saw_active, 0);
  endtask

  task automatic t_busy;
    run_op(3'd0, 4'd2, 32'h0, 0, 2'd0, 0, -1);
    chk(oc == 2'd0 && cyc == 3, "R2 no busy latency", cyc, 3);
    run_op(3'd0, 4'd2, 32'h0, 3, 2'd0, 0, -1);
    chk(oc == 2'd0 && cyc == 9, "R2 three busy latency", cyc, 9);
    chk(poll_cnt == 4, "R2 poll count", poll_cnt, 4);
    chk(dones == 1, "R10 single pulse", dones, 1);
  endtask

  task automatic t_irq;
    irq_i = 1; imask_i = 0;
    run_op(3'd1, 4'd1, 32'h0, 2, 2'd0, 0, -1);
    chk(oc == 2'd3 && kd == 2'd3, "R3 normal taken", {oc, kd}, 4'hF);
    chk(cyc == 4 && saw_abandon, "R3 abandon shown", cyc, 4);
    imask_i = 1;
    run_op(3'd1, 4'd1, 32'h0, 2, 2'd0, 0, -1);
    chk(oc == 2'd0 && cyc == 7, "R3 normal masked", {oc, 8'(cyc)}, 7);
    imask_i = 0; fiq_i = 1;
    run_op(3'd0, 4'd1, 32'h0, 1, 2'd0, 0, -1);
    chk(oc == 2'd3 && kd == 2'd2, "R3 fast over normal", kd, 2);
    rst_req_i = 1;
    run_op(3'd0, 4'd1, 32'h0, 1, 2'd0, 0, -1);
    chk(oc == 2'd3 && kd == 2'd1, "R3 reset first", kd, 1);
    rst_req_i = 0; fmask_i = 1;
    run_op(3'd0, 4'd1, 32'h0, 1, 2'd0, 0, -1);
    chk(oc == 2'd3 && kd == 2'd3, "R3 fast masked", kd, 3);
    irq_i = 0;
    run_op(3'd0, 4'd1, 32'h0, 1, 2'd0, 0, -1);
    chk(oc == 2'd0, "R3 all masked", oc, 0);
    fiq_i = 0; fmask_i = 0;
  endtask

  task automatic t_int_ignored;
    irq_i = 1; rst_req_i = 1;
    run_op(3'd0, 4'd3, 32'h0, 0, 2'd0, 0, -1);
    chk(oc == 2'd0 && kd == 2'd0, "R4 interrupts ignored", {oc, kd}, 0);
    irq_i = 0; rst_req_i = 0;
  endtask

  task automatic t_cant;
    run_op(3'd3, 4'd4, 32'h200, 1, 2'd2, 0, -1);
    chk(oc == 2'd2 && rd_cnt == 0, "R5 load refused", oc, 2);
    run_op(3'd0, 4'd4, 32'h0, 0, 2'd2, 0, -1);
    chk(oc == 2'd1, "R5 data op refused", oc, 1);
    run_op(3'd1, 4'd4, 32'h0, 0, 2'd2, 0, -1);
    chk(oc == 2'd1, "R5 move refused", oc, 1);
  endtask

  task automatic t_get;
    run_op(3'd2, 4'd6, 32'h0, 1, 2'd0, 0, -1);
    chk(oc == 2'd0 && res == 32'hCAFE_0123, "R6 read value", res, 32'hCAFE_0123);
    run_op(3'd2, 4'd6, 32'h0, 0, 2'd2, 0, -1);
    chk(oc == 2'd1 && res == 32'hA000_0000, "R6 refused read flags", res, 32'hA000_0000);
  endtask

  task automatic t_burst;
    run_op(3'd3, 4'd7, 32'h100, 0, 2'd0, 3, -1);
    chk(oc == 2'd0 && rd_cnt == 4 && wr_cnt == 0, "R7 load beats", rd_cnt, 4);
    for (int i = 0; i < 4; i++)
      chk(addr_log[i] == 32'h100 + 32'(4 * i), "R7 beat address", addr_log[i], 32'h100 + 32'(4 * i));
    run_op(3'd4, 4'd7, 32'h340, 1, 2'd0, 0, -1);
    chk(oc == 2'd0 && wr_cnt == 1 && rd_cnt == 0 && addr_log[0] == 32'h340, "R7 single store", wr_cnt, 1);
  endtask

  task automatic t_addrexc;
    run_op(3'd4, 4'd8, 32'h10, 0, 2'd0, 0, -1);
    chk(oc == 2'd2, "R8 store vector", oc, 2);
    run_op(3'd3, 4'd8, 32'h10, 0, 2'd0, 0, -1);
    chk(oc == 2'd0, "R8 load vector ok", oc, 0);
    run_op(3'd3, 4'd8, 32'h0400_0000, 0, 2'd0, 1, -1);
    chk(oc == 2'd2, "R8 load out of range", oc, 2);
    run_op(3'd4, 4'd8, 32'h20, 0, 2'd0, 0, -1);
    chk(oc == 2'd0, "R8 store above vectors", oc, 0);
  endtask

  task automatic t_ext_abort;
    run_op(3'd3, 4'd9, 32'h800, 0, 2'd0, 2, 1);
    chk(oc == 2'd2 && rd_cnt == 3, "R9 abort after burst", {oc, 8'(rd_cnt)}, 32'h203);
    run_op(3'd4, 4'd9, 32'h800, 0, 2'd0, 2, 2);
    chk(oc == 2'd2, "R9 abort on last beat", oc, 2);
  endtask

  task automatic t_restart;
    poke_at = 3;
    run_op(3'd0, 4'd2, 32'h0, 3, 2'd0, 0, -1);
    poke_at = -1;
    chk(oc == 2'd0 && cyc == 9, "R10 start ignored", {oc, 8'(cyc)}, 9);
    chk(dones == 1, "R10 no second pulse", dones, 1);
  endtask

  initial begin
    poke_at = -1; busy_n = 0; inc_n = 0; abort_at = -1; final_resp = 0;
    poll_cnt = 0; data_cnt = 0; rd_cnt = 0; wr_cnt = 0;
    #12 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_perm();
    t_busy();
    t_irq();
    t_int_ignored();
    t_cant();
    t_get();
    t_burst();
    t_addrexc();
    t_ext_abort();
    t_restart();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule